// File: doc/BRIEF.md
# Sliding-Window Descending Sorter

This block keeps the most recent N accepted samples of a W-bit stream and shows them on one wide bus, ordered from largest to smallest. Each accepted sample pushes out the sample that has been held longest, whatever its value. The bus therefore shows the sorted contents of a moving window of recent data, not a running maximum set.

A sample is first registered at the edge, then merged into a bank of ranked entries at the next edge. Each entry carries a small age tag. After reset the entries read zero and sort as ordinary zeros until real samples replace them. Comparison is unsigned over all W bits.

Top module: `window_sorter`

## Requirements
- R1: `win_sorted` packs the retained values in descending order, with the largest in bits [N*W-1 : (N-1)*W] and the smallest in bits [W-1:0].
- R2: A cycle with `rst` high at a rising edge sets every retained value to zero, so `win_sorted` reads all zeros after that edge.
- R3: After reset, the zero-filled slots take part in ordering as ordinary zero values. One sample v shows as v in the top slot and zeros below it.
- R4: Once N samples have been accepted, each new sample removes the sample that has been held longest, even when that sample is the largest retained value.
- R5: A sample presented with `smp_vld` high at rising edge k first appears on `win_sorted` after rising edge k+1.
- R6: While `smp_vld` is low at an edge, no sample is taken, and `win_sorted` keeps its value.
- R7: Ordering is unsigned magnitude, so with W=4 the value 0x8 ranks above 0x7.
- R8: Equal samples are all retained as separate entries. Among ties the newer one sits below the older one.
- R9: Reset takes priority over `smp_vld`. A sample presented during a reset cycle never appears on `win_sorted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe; `smp_in` is taken at an edge where this is high |
| smp_in | input | W | Sample value, unsigned |
| win_sorted | output | N*W | Retained window, sorted with the largest value in the top slot |

## Verification
A wrong age tag would not show until that entry should have left the window. It shows up to N accepted samples later, as a stale value that stays too long or a recent one that disappears early. A wrong insertion position shows one edge after the sample is merged, as a slot out of order. A broken capture stage shifts every result by a cycle. For these reasons the bench compares the whole bus after every edge, over long streams that fill and drain the window many times.

// File: rtl/ws_pkg.sv
`timescale 1ns/1ps
package ws_pkg;
  // width of the per-entry age tag for an N-entry window
  function automatic int unsigned age_w(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/ws_capture.sv
`timescale 1ns/1ps
module ws_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_i,
  input  logic [W-1:0] din_i,
  output logic         take_o,
  output logic [W-1:0] smp_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      take_o <= 1'b0;
      smp_o  <= '0;
    end else begin
      take_o <= vld_i;
      smp_o  <= din_i;
    end
  end
endmodule

// File: rtl/ws_insert_net.sv
`timescale 1ns/1ps
module ws_insert_net #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic [N-1:0][W-1:0]  val_i,
  input  logic [N-1:0][AW-1:0] age_i,
  input  logic [W-1:0]         smp_i,
  output logic [N-1:0][W-1:0]  val_o,
  output logic [N-1:0][AW-1:0] age_o,
  output logic [AW-1:0]        pos_o
);
  localparam logic [AW-1:0] OLDEST = AW'(N-1);

  // a held value stays above a fresh one on ties: newer sits lower
  function automatic logic stays_above(input logic [W-1:0] held, input logic [W-1:0] fresh);
    return held >= fresh;
  endfunction

  function automatic logic [AW-1:0] older(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  logic [N-2:0][W-1:0]  rem_v;
  logic [N-2:0][AW-1:0] rem_a;
  int ev, ps, m, k;

  always_comb begin
    ev = 0;
    for (int i = 0; i < N; i++)
      if (age_i[i] == OLDEST) ev = i;
    // squeeze out the evicted entry, keeping rank order
    for (int j = 0; j < N-1; j++) begin
      if (j < ev) begin
        rem_v[j] = val_i[j];
        rem_a[j] = older(age_i[j]);
      end else begin
        rem_v[j] = val_i[j+1];
        rem_a[j] = older(age_i[j+1]);
      end
    end
    ps = 0;
    for (int j = 0; j < N-1; j++)
      if (stays_above(rem_v[j], smp_i)) ps = ps + 1;
    for (int i = 0; i < N; i++) begin
      m = (i < N-1) ? i : N-2;
      k = (i > 0) ? i-1 : 0;
      if (i < ps) begin
        val_o[i] = rem_v[m];
        age_o[i] = rem_a[m];
      end else if (i == ps) begin
        val_o[i] = smp_i;
        age_o[i] = '0;
      end else begin
        val_o[i] = rem_v[k];
        age_o[i] = rem_a[k];
      end
    end
    pos_o = AW'(ps);
  end
endmodule

// File: rtl/ws_entry_bank.sv
`timescale 1ns/1ps
module ws_entry_bank #(
  parameter int W  = 16,
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take_i,
  input  logic [N-1:0][W-1:0]  val_n,
  input  logic [N-1:0][AW-1:0] age_n,
  output logic [N-1:0][W-1:0]  val_q,
  output logic [N-1:0][AW-1:0] age_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < N; r++) begin
        val_q[r] <= '0;
        age_q[r] <= AW'(N-1-r);   // top rank counts as the oldest zero
      end
    end else if (take_i) begin
      val_q <= val_n;
      age_q <= age_n;
    end
  end

  logic [(1<<AW)-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int r = 0; r < N; r++) age_seen[age_q[r]] = 1'b1;
  end

  generate
    for (genvar r = 0; r < N-1; r++) begin : g_ord
      p_rank_order_r1: assert property (@(posedge clk) disable iff (rst)
        val_q[r] >= val_q[r+1]);
    end
  endgenerate

  p_ages_distinct_r4: assert property (@(posedge clk) disable iff (rst)
    $countones(age_seen) == N);

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> ($stable(val_q) && $stable(age_q)));

  p_reset_clear_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (val_q == '0));
endmodule

// File: rtl/window_sorter.sv
`timescale 1ns/1ps
module window_sorter #(
  parameter int W = 16,
  parameter int N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           smp_vld,
  input  logic [W-1:0]   smp_in,
  output logic [N*W-1:0] win_sorted
);
  localparam int AW = ws_pkg::age_w(N);

  logic                 take;
  logic [W-1:0]         smp;
  logic [N-1:0][W-1:0]  val_q, val_n;
  logic [N-1:0][AW-1:0] age_q, age_n;
  logic [AW-1:0]        ins_pos;
  logic [W-1:0]         newest;

  ws_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .vld_i(smp_vld), .din_i(smp_in),
    .take_o(take), .smp_o(smp)
  );

  ws_insert_net #(.W(W), .N(N), .AW(AW)) u_net (
    .val_i(val_q), .age_i(age_q), .smp_i(smp),
    .val_o(val_n), .age_o(age_n), .pos_o(ins_pos)
  );

  ws_entry_bank #(.W(W), .N(N), .AW(AW)) u_bank (
    .clk(clk), .rst(rst), .take_i(take),
    .val_n(val_n), .age_n(age_n), .val_q(val_q), .age_q(age_q)
  );

  generate
    for (genvar r = 0; r < N; r++) begin : g_out
      assign win_sorted[(N-1-r)*W +: W] = val_q[r];
    end
  endgenerate

  always_comb begin
    newest = '0;
    for (int r = 0; r < N; r++)
      if (age_q[r] == '0) newest = val_q[r];
  end

  p_capture_r5: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> take);

  p_newest_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> (newest == $past(smp)));

  p_slot_fill_r3: assert property (@(posedge clk) disable iff (rst)
    take |=> (val_q[$past(ins_pos)] == $past(smp)));
endmodule

// File: tb/window_sorter_bench.sv
`timescale 1ns/1ps
module window_sorter_bench;
  localparam int W = 4;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           vld = 1'b0;
  logic [W-1:0]   din = '0;
  logic [N*W-1:0] out;

  int total = 0;
  int bad   = 0;
  int hist[N];
  bit pv;
  int pd;

  always #10 clk = ~clk;

  window_sorter #(.W(W), .N(N)) u_window_sorter (
    .clk(clk), .rst(rst), .smp_vld(vld), .smp_in(din), .win_sorted(out)
  );

  function automatic logic [N*W-1:0] expect_bus();
    int s[N];
    logic [N*W-1:0] res;
    for (int i = 0; i < N; i++) s[i] = hist[i];
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N-1-a; b++)
        if (s[b] < s[b+1]) begin
          int t = s[b]; s[b] = s[b+1]; s[b+1] = t;
        end
    res = '0;
    for (int i = 0; i < N; i++) res = (res << W) | (N*W)'(s[i]);
    return res;
  endfunction

  task automatic check(input string tag, input logic [N*W-1:0] exp);
    total++;
    if (out !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, out, exp);
    end
  endtask

  task automatic step(input logic r, input logic v, input int d, input string tag);
    @(negedge clk);
    rst = r; vld = v; din = W'(d);
    @(posedge clk);
    #1;
    if (r) begin
      for (int i = 0; i < N; i++) hist[i] = 0;
      pv = 0;
    end else begin
      if (pv) begin
        for (int i = N-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = pd;
      end
      pv = v; pd = d;
    end
    check(tag, expect_bus());
  endtask

  initial begin
    #(20 * 190000);
    bad++; total++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) hist[i] = 0;
    pv = 0; pd = 0;
    step(1, 0, 0, "R2 reset");
    step(1, 0, 0, "R2 reset");
    check("R2 reset zero", '0);
    // R5: first sample not visible after its own edge
    step(0, 1, 5, "R5 latency");
    check("R5 still zero", '0);
    step(0, 0, 0, "R3 single");
    check("R3 single sample", 16'h5000);
    // R6: idle cycles hold
    step(0, 0, 9, "R6 idle");
    step(0, 0, 3, "R6 idle");
    check("R6 hold", 16'h5000);
    // R4: oldest leaves even when largest
    step(0, 1, 15, "R4 fill");
    step(0, 1, 1, "R4 fill");
    step(0, 1, 2, "R4 fill");
    step(0, 1, 3, "R4 fill");
    step(0, 1, 4, "R4 evict");
    step(0, 0, 0, "R4 evict");
    check("R4 largest evicted", 16'h4321);
    // R7: unsigned ordering
    step(0, 1, 7, "R7");
    step(0, 1, 8, "R7");
    step(0, 0, 0, "R7");
    check("R7 unsigned", 16'h8743);
    // R8: duplicates retained
    step(0, 1, 6, "R8");
    step(0, 1, 6, "R8");
    step(0, 1, 6, "R8");
    step(0, 1, 2, "R8");
    step(0, 0, 0, "R8");
    check("R8 duplicates", 16'h6662);
    // R9: reset wins over a valid sample
    step(1, 1, 14, "R9 reset with valid");
    step(0, 0, 0, "R9");
    step(0, 0, 0, "R9");
    check("R9 sample dropped", '0);
    // R1/R4/R6: sweep of all three-sample groups with gapped strobes
    for (int k = 0; k < 4096; k++)
      for (int j = 0; j < 3; j++)
        step(0, ((k * 3 + j) % 5) != 0, (k >> (4 * j)) & 15, "R1 sweep");
    for (int j = 0; j < 3; j++) step(0, 0, 0, "R1 drain");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule